// File: doc/BRIEF.md
# Privileged Control Register Bank

This block holds the machine-control state of a small processor core: a bank of thirty-two 32-bit control registers reached by a 5-bit index. The pipeline presents one operation per cycle (read, write, exception return or debug return). A read returns its value combinationally in the same cycle. A write, or a return, updates the bank at the next clock edge. The bank also takes the external interrupt lines and drives the run-status word, the user-mode flag and an interrupt request towards the core.

Each register has a writable mask, a read-only mask and a reset value, all set by parameters. The pending-interrupt slot holds no storage and always shows the live interrupt lines gated by the enable register. The unassigned slots have no storage and read as zero. Every operation is privileged: in user mode it raises a fault and changes nothing. The two return operations copy a saved status word back into the run-status register and hand the return address, taken from the core's general registers, to the fetch unit.

Top module: `privctl_bank`

## Requirements
- R1: After reset the run-status register (index 0) is zero, which means supervisor mode with interrupts off. Every stored register holds its INIT value, and irq_req and resync are low.
- R2: Indices 6, 11 and 16 to 31 are unassigned. A read of one of them returns zero, and a write to one of them has no effect, whatever masks are configured for it.
- R3: A read of index 4 returns irq_lines AND the enable register (index 3) in the same cycle the lines are presented. A write to index 4 is ignored.
- R4: A write to a register whose writable mask is all zero leaves the register unchanged.
- R5: A write to a register whose writable mask is all ones stores the whole written word, whatever its read-only mask is.
- R6: For any other writable mask W and read-only mask R, a write stores (wdata & W) | (old & R).
- R7: When status bit 1 is set (user mode), op_kind 1 (read), 2 (write), 3 (exception return) and 4 (debug return) each raise priv_fault in the same cycle. The faulting operation gives rd_valid = 0, rd_data = 0 and ret_valid = 0, and no register changes.
- R8: An exception return (op_kind 3) in supervisor mode drives ret_valid with ret_pc = ea_in in the same cycle. From the next edge the run-status register holds the saved exception status (index 1).
- R9: A debug return (op_kind 4) in supervisor mode drives ret_valid with ret_pc = ba_in in the same cycle. From the next edge the run-status register holds the saved debug status (index 2).
- R10: irq_req = status bit 0 AND (irq_lines AND enable register) is nonzero. It is combinational on the interrupt lines.
- R11: A supervisor write to index 0 or index 3 raises resync for exactly one cycle, the cycle after the write. No other operation raises it.
- R12: A supervisor read (op_kind 1) drives rd_valid and rd_data in the same cycle. An op_kind of 0 or of 5 to 7 does nothing and raises no fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_kind | input | 3 | 1 read, 2 write, 3 exception return, 4 debug return |
| op_idx | input | 5 | Register index |
| op_wdata | input | 32 | Write data |
| ea_in | input | 32 | Exception return address from the general registers |
| ba_in | input | 32 | Debug return address from the general registers |
| irq_lines | input | 32 | External interrupt lines |
| rd_valid | output | 1 | Read accepted this cycle |
| rd_data | output | 32 | Read value, zero when rd_valid is low |
| priv_fault | output | 1 | Privileged operation attempted in user mode |
| ret_valid | output | 1 | Return accepted this cycle |
| ret_pc | output | 32 | Return address, zero when ret_valid is low |
| status_o | output | 32 | Current run-status register |
| user_mode | output | 1 | Status bit 1 |
| irq_req | output | 1 | Interrupt request to the core |
| resync | output | 1 | Pending interrupts must be re-evaluated |

## Verification
An interrupt evaluation and a write to the enable or status register can fall in the same cycle. The bench provokes this by changing irq_lines at the same drive point as the write. It then checks that irq_req still follows the old register contents in that cycle, and follows the new contents together with a one-cycle resync pulse after the edge. A read of the pending slot can also fall in the same cycle as a change on the interrupt lines. The bench drives both together and expects the read data to reflect the new lines at once. A user-mode write to the enable register is judged through irq_req, which must keep its previous value.

// File: rtl/privctl_pkg.sv
package privctl_pkg;

    localparam int CR_COUNT = 32;
    localparam int CR_XLEN  = 32;

    localparam int CR_RUN        = 0;
    localparam int CR_RUN_EXC    = 1;
    localparam int CR_RUN_DBG    = 2;
    localparam int CR_IRQ_EN     = 3;
    localparam int CR_IRQ_PEND   = 4;
    localparam int CR_IDENT      = 5;
    localparam int CR_CAUSE      = 7;
    localparam int CR_MAP_ADDR   = 8;
    localparam int CR_MAP_DATA   = 9;
    localparam int CR_MAP_CTRL   = 10;
    localparam int CR_FAULT_ADDR = 12;
    localparam int CR_CFG        = 13;
    localparam int CR_PROT_BASE  = 14;
    localparam int CR_PROT_DATA  = 15;

    localparam int ST_IE_BIT   = 0;
    localparam int ST_USER_BIT = 1;

    typedef enum logic [2:0] {
        OPK_NONE = 3'd0,
        OPK_RD   = 3'd1,
        OPK_WR   = 3'd2,
        OPK_ERET = 3'd3,
        OPK_BRET = 3'd4
    } op_kind_e;

    typedef logic [CR_COUNT-1:0][CR_XLEN-1:0] cr_table_t;

    function automatic logic slot_unassigned(input int i);
        return (i == 6) || (i == 11) || (i >= 16);
    endfunction

    function automatic cr_table_t dflt_wmask();
        cr_table_t t = '0;
        t[CR_RUN]       = 32'h0000_0003;
        t[CR_RUN_EXC]   = 32'h0000_0003;
        t[CR_RUN_DBG]   = 32'h0000_0003;
        t[CR_IRQ_EN]    = '1;
        t[CR_MAP_ADDR]  = '1;
        t[CR_MAP_DATA]  = '1;
        t[CR_MAP_CTRL]  = '1;
        t[CR_CFG]       = 32'h0000_00FF;
        t[CR_PROT_BASE] = '1;
        t[CR_PROT_DATA] = '1;
        return t;
    endfunction

    function automatic cr_table_t dflt_rmask();
        cr_table_t t = '0;
        t[CR_IDENT]      = '1;
        t[CR_CAUSE]      = '1;
        t[CR_FAULT_ADDR] = '1;
        t[CR_CFG]        = 32'h0000_FF00;
        return t;
    endfunction

    function automatic cr_table_t dflt_init();
        cr_table_t t = '0;
        t[CR_IDENT] = 32'h0000_0100;
        t[CR_CFG]   = 32'h0000_3C00;
        return t;
    endfunction

endpackage

// File: rtl/privctl_merge.sv
module privctl_merge #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] old_val,
    input  logic [XLEN-1:0] wr_val,
    input  logic [XLEN-1:0] wmask,
    input  logic [XLEN-1:0] rmask,
    output logic [XLEN-1:0] new_val
);
    always_comb begin
        if (wmask == '0) begin
            new_val = old_val;
        end else if (&wmask) begin
            new_val = wr_val;
        end else begin
            new_val = (wr_val & wmask) | (old_val & rmask);
        end
    end
endmodule

// File: rtl/privctl_rdmux.sv
module privctl_rdmux
    import privctl_pkg::*;
#(
    parameter int XLEN = 32,
    localparam int IDXW = $clog2(CR_COUNT)
) (
    input  logic [CR_COUNT-1:0][XLEN-1:0] regs,
    input  logic [IDXW-1:0]               idx,
    input  logic [XLEN-1:0]               irq_ext,
    output logic [XLEN-1:0]               val
);
    logic [CR_COUNT-1:0][XLEN-1:0] view;

    for (genvar i = 0; i < CR_COUNT; i++) begin : g_view
        if (slot_unassigned(i)) begin : g_zero
            assign view[i] = '0;
        end else if (i == CR_IRQ_PEND) begin : g_pend
            assign view[i] = regs[CR_IRQ_EN] & irq_ext;
        end else begin : g_store
            assign view[i] = regs[i];
        end
    end

    assign val = view[idx];
endmodule

// File: rtl/privctl_irq.sv
module privctl_irq
    import privctl_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] run_status,
    input  logic [XLEN-1:0] irq_en,
    input  logic [XLEN-1:0] irq_ext,
    output logic            req
);
    assign req = run_status[ST_IE_BIT] & (|(irq_en & irq_ext));
endmodule

// File: rtl/privctl_bank.sv
module privctl_bank
    import privctl_pkg::*;
#(
    parameter int XLEN = CR_XLEN,
    parameter int NIRQ = 32,
    parameter logic [CR_COUNT-1:0][XLEN-1:0] WMASK = dflt_wmask(),
    parameter logic [CR_COUNT-1:0][XLEN-1:0] RMASK = dflt_rmask(),
    parameter logic [CR_COUNT-1:0][XLEN-1:0] INIT  = dflt_init(),
    localparam int IDXW = $clog2(CR_COUNT)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            op_valid,
    input  logic [2:0]      op_kind,
    input  logic [IDXW-1:0] op_idx,
    input  logic [XLEN-1:0] op_wdata,
    input  logic [XLEN-1:0] ea_in,
    input  logic [XLEN-1:0] ba_in,
    input  logic [NIRQ-1:0] irq_lines,
    output logic            rd_valid,
    output logic [XLEN-1:0] rd_data,
    output logic            priv_fault,
    output logic            ret_valid,
    output logic [XLEN-1:0] ret_pc,
    output logic [XLEN-1:0] status_o,
    output logic            user_mode,
    output logic            irq_req,
    output logic            resync
);
    typedef struct packed {
        logic [CR_COUNT-1:0][XLEN-1:0] regs;
        logic                          resync;
    } bank_t;

    bank_t state_d, state_q;

    logic [XLEN-1:0] irq_ext;
    logic [XLEN-1:0] run_q, run_exc_q, run_dbg_q, irq_en_q;
    logic [XLEN-1:0] sel_old, sel_w, sel_r, merged, rd_view;
    logic            is_priv_op, sup, legal;
    logic            do_rd, do_wr, do_eret, do_bret, target_ok;

    assign irq_ext   = XLEN'(irq_lines);
    assign run_q     = state_q.regs[CR_RUN];
    assign run_exc_q = state_q.regs[CR_RUN_EXC];
    assign run_dbg_q = state_q.regs[CR_RUN_DBG];
    assign irq_en_q  = state_q.regs[CR_IRQ_EN];

    // Operation qualification
    assign sup        = ~run_q[ST_USER_BIT];
    assign is_priv_op = op_valid && (op_kind == OPK_RD || op_kind == OPK_WR ||
                                     op_kind == OPK_ERET || op_kind == OPK_BRET);
    assign legal      = is_priv_op && sup;
    assign do_rd      = legal && (op_kind == OPK_RD);
    assign do_wr      = legal && (op_kind == OPK_WR);
    assign do_eret    = legal && (op_kind == OPK_ERET);
    assign do_bret    = legal && (op_kind == OPK_BRET);
    assign target_ok  = !slot_unassigned(int'(op_idx)) && (int'(op_idx) != CR_IRQ_PEND);

    // Mask selection for the addressed register
    assign sel_old = state_q.regs[op_idx];
    assign sel_w   = WMASK[op_idx];
    assign sel_r   = RMASK[op_idx];

    privctl_merge #(.XLEN(XLEN)) u_merge (
        .old_val (sel_old),
        .wr_val  (op_wdata),
        .wmask   (sel_w),
        .rmask   (sel_r),
        .new_val (merged)
    );

    privctl_rdmux #(.XLEN(XLEN)) u_rdmux (
        .regs    (state_q.regs),
        .idx     (op_idx),
        .irq_ext (irq_ext),
        .val     (rd_view)
    );

    privctl_irq #(.XLEN(XLEN)) u_irq (
        .run_status (run_q),
        .irq_en     (irq_en_q),
        .irq_ext    (irq_ext),
        .req        (irq_req)
    );

    // Next-state computation
    always_comb begin
        state_d        = state_q;
        state_d.resync = 1'b0;
        if (do_wr && target_ok) begin
            state_d.regs[op_idx] = merged;
            state_d.resync = (int'(op_idx) == CR_RUN) || (int'(op_idx) == CR_IRQ_EN);
        end
        if (do_eret) begin
            state_d.regs[CR_RUN] = run_exc_q;
        end
        if (do_bret) begin
            state_d.regs[CR_RUN] = run_dbg_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.regs   <= INIT;
            state_q.resync <= 1'b0;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs
    assign rd_valid   = do_rd;
    assign rd_data    = do_rd ? rd_view : '0;
    assign priv_fault = is_priv_op && !sup;
    assign ret_valid  = do_eret || do_bret;
    assign ret_pc     = do_eret ? ea_in : (do_bret ? ba_in : '0);
    assign status_o   = run_q;
    assign user_mode  = run_q[ST_USER_BIT];
    assign resync     = state_q.resync;

endmodule

// File: rtl/privctl_bank_chk.sv
module privctl_bank_chk
    import privctl_pkg::*;
#(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            op_valid,
    input logic [2:0]      op_kind,
    input logic [4:0]      op_idx,
    input logic            rd_valid,
    input logic [XLEN-1:0] rd_data,
    input logic            priv_fault,
    input logic            ret_valid,
    input logic [XLEN-1:0] status_o,
    input logic            irq_req,
    input logic            resync,
    input logic [XLEN-1:0] run_exc,
    input logic [XLEN-1:0] run_dbg
);
    // R7
    fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        priv_fault |=> $stable(status_o));

    // R7
    fault_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        priv_fault |-> (!rd_valid && !ret_valid));

    // R8
    eret_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid && op_kind == OPK_ERET) |=> (status_o == $past(run_exc)));

    // R9
    bret_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid && op_kind == OPK_BRET) |=> (status_o == $past(run_dbg)));

    // R10
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> status_o[ST_IE_BIT]);

    // R11
    resync_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resync |-> $past(op_valid && op_kind == OPK_WR && !status_o[ST_USER_BIT] &&
                         (op_idx == 5'd0 || op_idx == 5'd3)));

    // R2
    unassigned_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && (op_idx == 5'd6 || op_idx == 5'd11 || op_idx >= 5'd16)) |-> (rd_data == '0));
endmodule

bind privctl_bank privctl_bank_chk #(.XLEN(XLEN)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_valid   (op_valid),
    .op_kind    (op_kind),
    .op_idx     (op_idx),
    .rd_valid   (rd_valid),
    .rd_data    (rd_data),
    .priv_fault (priv_fault),
    .ret_valid  (ret_valid),
    .status_o   (status_o),
    .irq_req    (irq_req),
    .resync     (resync),
    .run_exc    (run_exc_q),
    .run_dbg    (run_dbg_q)
);

// File: tb/sim_privctl_bank.sv
`timescale 1ns/1ps
module sim_privctl_bank;
    import privctl_pkg::*;

    function automatic logic [31:0] hsh(input int i, input int salt);
        return ((32'(i) + 32'd1) * 32'h9E37_79B9) ^ (32'(salt) * 32'h7F4A_7C15) ^ 32'h3C6E_F372;
    endfunction

    function automatic logic [31:0] tbw(input int i);
        if (i <= 2) return 32'h3;
        if (i == 3) return '1;
        if (i % 3 == 0) return '1;
        if (i % 3 == 1) return '0;
        return hsh(i, 1);
    endfunction

    function automatic logic [31:0] tbr(input int i);
        if (i <= 3) return '0;
        if (i % 3 == 2) return hsh(i, 2) & ~tbw(i);
        return hsh(i, 2);
    endfunction

    function automatic logic [31:0] tbi(input int i);
        if (i == 0 || i == 3) return '0;
        return hsh(i, 3);
    endfunction

    function automatic cr_table_t mk_w();
        cr_table_t t;
        for (int i = 0; i < 32; i++) t[i] = tbw(i);
        return t;
    endfunction
    function automatic cr_table_t mk_r();
        cr_table_t t;
        for (int i = 0; i < 32; i++) t[i] = tbr(i);
        return t;
    endfunction
    function automatic cr_table_t mk_i();
        cr_table_t t;
        for (int i = 0; i < 32; i++) t[i] = tbi(i);
        return t;
    endfunction

    localparam cr_table_t TB_W = mk_w();
    localparam cr_table_t TB_R = mk_r();
    localparam cr_table_t TB_I = mk_i();

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [2:0]  op_kind = 3'd0;
    logic [4:0]  op_idx = 5'd0;
    logic [31:0] op_wdata = '0, ea_in = '0, ba_in = '0, irq_lines = '0;
    logic        rd_valid, priv_fault, ret_valid, user_mode, irq_req, resync;
    logic [31:0] rd_data, ret_pc, status_o;

    int n_chk = 0, n_bad = 0;
    logic [31:0] m [32];

    always #2.5 clk = ~clk;

    privctl_bank #(.WMASK(TB_W), .RMASK(TB_R), .INIT(TB_I)) u0 (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
        .op_idx(op_idx), .op_wdata(op_wdata), .ea_in(ea_in), .ba_in(ba_in),
        .irq_lines(irq_lines), .rd_valid(rd_valid), .rd_data(rd_data),
        .priv_fault(priv_fault), .ret_valid(ret_valid), .ret_pc(ret_pc),
        .status_o(status_o), .user_mode(user_mode), .irq_req(irq_req), .resync(resync)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic unas(input int i);
        return (i == 6) || (i == 11) || (i >= 16);
    endfunction

    function automatic logic [31:0] exp_rd(input int i);
        if (unas(i)) return '0;
        if (i == 4) return irq_lines & m[3];
        return m[i];
    endfunction

    function automatic string tag_of(input int i);
        if (unas(i)) return "R2";
        if (i == 4) return "R3";
        if (tbw(i) == '0) return "R4";
        if (&tbw(i)) return "R5";
        return "R6";
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 32; i++) m[i] = tbi(i);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        op_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        #1;
        chk("R1 status", status_o, 32'h0);
        chk("R1 resync", {31'b0, resync}, 32'h0);
    endtask

    task automatic op(input logic [2:0] k, input int ix, input logic [31:0] wd,
                      input logic [31:0] irqv, input string tag);
        logic usr, ex_res;
        logic [31:0] ex_rd, w, r;
        @(negedge clk);
        op_valid = 1'b1; op_kind = k; op_idx = 5'(ix); op_wdata = wd; irq_lines = irqv;
        #1;
        usr = m[0][1];
        ex_rd = (!usr && k == OPK_RD) ? exp_rd(ix) : 32'h0;
        chk({tag, " fault R7"}, {31'b0, priv_fault}, {31'b0, usr && k >= 3'd1 && k <= 3'd4});
        chk({tag, " rd_valid R12"}, {31'b0, rd_valid}, {31'b0, !usr && k == OPK_RD});
        chk({tag, " rd_data"}, rd_data, ex_rd);
        chk({tag, " ret_valid"}, {31'b0, ret_valid}, {31'b0, !usr && (k == OPK_ERET || k == OPK_BRET)});
        chk({tag, " ret_pc"}, ret_pc, (!usr && k == OPK_ERET) ? ea_in :
                                      (!usr && k == OPK_BRET) ? ba_in : 32'h0);
        chk({tag, " irq_req R10"}, {31'b0, irq_req}, {31'b0, m[0][0] && ((irqv & m[3]) != 0)});
        ex_res = 1'b0;
        if (!usr) begin
            if (k == OPK_WR && !unas(ix) && ix != 4) begin
                w = tbw(ix); r = tbr(ix);
                if (w == '0) ;
                else if (&w) m[ix] = wd;
                else m[ix] = (wd & w) | (m[ix] & r);
                ex_res = (ix == 0 || ix == 3);
            end
            if (k == OPK_ERET) m[0] = m[1];
            if (k == OPK_BRET) m[0] = m[2];
        end
        @(negedge clk);
        op_valid = 1'b0;
        #1;
        chk({tag, " resync R11"}, {31'b0, resync}, {31'b0, ex_res});
        chk({tag, " status"}, status_o, m[0]);
        chk({tag, " user_mode"}, {31'b0, user_mode}, {31'b0, m[0][1]});
    endtask

    initial begin
        #(200000 * 5);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int ix;
        void'($urandom(32'd20240611));
        model_reset();
        do_reset();
        chk("R1 irq_req", {31'b0, irq_req}, 32'h0);
        // R1 R2: every slot reads its reset value or zero
        for (int i = 0; i < 32; i++) op(OPK_RD, i, 0, 32'h0, unas(i) ? "R2" : "R1");

        // R2 R3 R4 R5 R6: random writes then read-back
        for (int n = 0; n < 400; n++) begin
            ix = int'($urandom % 32);
            d = $urandom;
            if (ix == 0) d[1] = 1'b0;
            op(OPK_WR, ix, d, irq_lines, tag_of(ix));
            op(OPK_RD, ix, 0, irq_lines, tag_of(ix));
        end

        // R5 R6 directed extremes
        op(OPK_WR, 5, 32'hFFFF_FFFF, 0, "R6"); op(OPK_RD, 5, 0, 0, "R6");
        op(OPK_WR, 5, 32'h0, 0, "R6");          op(OPK_RD, 5, 0, 0, "R6");
        op(OPK_WR, 9, 32'h0, 0, "R5");          op(OPK_RD, 9, 0, 0, "R5");
        op(OPK_WR, 7, 32'hFFFF_FFFF, 0, "R4");  op(OPK_RD, 7, 0, 0, "R4");
        op(OPK_WR, 20, 32'hFFFF_FFFF, 0, "R2"); op(OPK_RD, 20, 0, 0, "R2");

        // R3: pending view tracks lines in the same cycle
        op(OPK_WR, 3, 32'h0F0F_00FF, 0, "R3");
        op(OPK_WR, 4, 32'hFFFF_FFFF, 0, "R3");
        for (int n = 0; n < 40; n++) op(OPK_RD, 4, 0, $urandom, "R3");

        // R10 R11: enable write while lines change in the same cycle
        op(OPK_WR, 0, 32'h1, 32'h0000_0100, "R11");
        op(OPK_WR, 3, 32'h0000_0100, 32'h0000_0100, "R11");
        op(OPK_RD, 13, 0, 32'h0000_0100, "R10");
        op(OPK_WR, 3, 32'h0, 32'h0000_0300, "R11");
        op(OPK_RD, 13, 0, 32'h0000_0300, "R10");
        op(OPK_WR, 8, 32'h1234_5678, 32'h0, "R11");
        for (int n = 0; n < 30; n++) op(OPK_WR, 3, $urandom, $urandom, "R10");
        op(OPK_NONE, 3, 32'h0, 0, "R12");
        op(3'd6, 3, 32'h0, 0, "R12");

        // R8 R9: returns
        op(OPK_WR, 1, 32'h1, 0, "R8");
        op(OPK_WR, 2, 32'h3, 0, "R9");
        op(OPK_WR, 3, 32'hFF, 0, "R8");
        op(OPK_WR, 0, 32'h0, 0, "R8");
        ea_in = 32'hDEAD_BEE0; ba_in = 32'h0BAD_F00C;
        op(OPK_ERET, 0, 0, 32'h10, "R8");
        op(OPK_BRET, 0, 0, 32'h10, "R9");

        // R7: user mode rejects everything
        op(OPK_WR, 3, 32'h0, 32'h10, "R7");
        op(OPK_RD, 13, 0, 32'h10, "R7");
        op(OPK_WR, 0, 32'h0, 32'h10, "R7");
        op(OPK_ERET, 0, 0, 32'h10, "R7");
        op(OPK_BRET, 0, 0, 32'h10, "R7");
        chk("R7 irq_req", {31'b0, irq_req}, 32'h1);

        do_reset();
        op(OPK_RD, 13, 0, 0, "R1");
        op(OPK_RD, 3, 0, 0, "R1");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule